// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device and finds out when an embedded program or erase operation inside the flash has finished. After a one-cycle start request carrying a target address and a bound on the number of comparisons, it reads that address over and over through a request/acknowledge read port. While the operation is still running, the flash inverts data bit 6 on every read of that location. When two consecutive completed reads return the same bit 6 value, the operation has stopped.

Data bit 5 is the flash's error flag. If it reads as 1 during polling, bit 6 may have stopped toggling on that same read. The poller therefore discards its history and takes a fresh pair of reads. A stable bit 6 in that pair means pass, and a differing bit 6 means fail. If the comparison bound runs out while bit 6 keeps toggling, the poller reports a timeout. Program and erase operations go through the same procedure, and the block never needs the data value that was written.

The result is a one-cycle done pulse together with a two-bit status code. The status code keeps its value until the next result is reported.

Top module: `flash_toggle_poll`

## Requirements
- R1: After reset, busy_o, done_o and rd_req_o are 0 and status_o is 2'b00.
- R2: A start_i pulse while idle latches addr_i and begins polling. rd_req_o stays high until a cycle with rd_ack_i high, and rd_addr_o equals the latched address for every read of the run.
- R3: A read completes in a cycle where rd_req_o and rd_ack_i are both 1, and rd_data_i is sampled in that cycle. During polling, each completed read is compared on bit 6 with the previous completed read. When the two are equal and bit 5 of the later read is 0, the run ends with status 2'b00 (pass).
- R4: Each comparison in which bit 6 differs counts once. When the count reaches limit_i (a limit_i of 0 acts as 1) without a match, the run ends with status 2'b10 (timeout).
- R5: A polling read with bit 5 equal to 1 ends polling, including on the first read. Exactly two further reads follow. Equal bit 6 in those two reads gives status 2'b00 (pass), and different bit 6 gives status 2'b01 (fail). Bit 5 is ignored during these two reads.
- R6: start_i is ignored while busy_o is 1. The latched address does not change and no extra run or done pulse results.
- R7: done_o is high for exactly one cycle, in the cycle after the final read completes. busy_o falls in that same cycle. status_o changes only when done_o is 1 and holds its value until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| addr_i | input | AW | Location to poll, taken with start_i |
| limit_i | input | CW | Maximum number of toggling comparisons, taken with start_i |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 8 | Read data |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 pass, 01 fail, 10 timeout |

## Verification
The assertions assume that rd_ack_i is high only in cycles where rd_req_o is also high, and that rd_data_i is valid in every cycle where a read completes. The bench's flash responder drives rd_ack_i and rd_data_i only at falling edges where it sees rd_req_o high, with random acknowledge delays. Its bit 6 alternates per completed read until a chosen read index and then holds. Bit 5 rises from a chosen read index onward, and the remaining data bits are random so that they cannot influence the result.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

  localparam int unsigned DATA_W     = 8;
  localparam int unsigned TOGGLE_BIT = 6;
  localparam int unsigned ERROR_BIT  = 5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FIRST = 3'd1,
    ST_NEXT  = 3'd2,
    ST_CHK_A = 3'd3,
    ST_CHK_B = 3'd4
  } ftp_state_e;

  typedef enum logic [1:0] {
    RES_PASS    = 2'b00,
    RES_FAIL    = 2'b01,
    RES_TIMEOUT = 2'b10
  } ftp_result_e;

endpackage

// File: rtl/ftp_ref_reg.sv
// Holds bit 6 of the previous completed read; reports a difference
// against the read completing in the current cycle.
module ftp_ref_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic bit_i,
  output logic differs_o
);

  logic ref_q;
  logic ref_d;

  always_comb begin
    ref_d = ref_q;
    if (load_i) ref_d = bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end

  assign differs_o = ref_q ^ bit_i;

endmodule

// File: rtl/ftp_pair_cnt.sv
// Counts toggling comparisons against a latched bound.
module ftp_pair_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          inc_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;
  logic [CW:0]   cnt_plus;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (arm_i) begin
      cnt_d = '0;
      lim_d = (limit_i == '0) ? CW'(1) : limit_i;
    end else if (inc_i) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= CW'(1);
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign cnt_plus = {1'b0, cnt_q} + (CW+1)'(1);
  assign last_o   = (cnt_plus >= {1'b0, lim_q});

  // R4: the count never reaches the bound while still running
  a_r4_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim_q);

endmodule

// File: rtl/ftp_ctrl.sv
// Sequencer: polling loop, error re-check pair, result reporting.
module ftp_ctrl
  import ftp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       ack_i,
  input  logic       tog_i,
  input  logic       err_i,
  input  logic       differs_i,
  input  logic       last_i,
  output logic       accept_o,
  output logic       req_o,
  output logic       ref_load_o,
  output logic       cnt_arm_o,
  output logic       cnt_inc_o,
  output logic       done_o,
  output logic [1:0] status_o
);

  ftp_state_e  state_q, state_d;
  logic        done_q, done_d;
  ftp_result_e res_q, res_d;
  logic        fire;

  assign req_o    = (state_q != ST_IDLE);
  assign fire     = req_o & ack_i;
  assign accept_o = (state_q == ST_IDLE) & start_i;

  always_comb begin
    state_d    = state_q;
    done_d     = 1'b0;
    res_d      = res_q;
    ref_load_o = 1'b0;
    cnt_arm_o  = 1'b0;
    cnt_inc_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cnt_arm_o = 1'b1;
          state_d   = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (fire) begin
          if (err_i) begin
            state_d = ST_CHK_A;
          end else begin
            ref_load_o = 1'b1;
            state_d    = ST_NEXT;
          end
        end
      end
      ST_NEXT: begin
        if (fire) begin
          if (err_i) begin
            state_d = ST_CHK_A;
          end else if (!differs_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            res_d   = RES_PASS;
          end else if (last_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            res_d   = RES_TIMEOUT;
          end else begin
            ref_load_o = 1'b1;
            cnt_inc_o  = 1'b1;
          end
        end
      end
      ST_CHK_A: begin
        if (fire) begin
          ref_load_o = 1'b1;
          state_d    = ST_CHK_B;
        end
      end
      ST_CHK_B: begin
        if (fire) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          res_d   = differs_i ? RES_FAIL : RES_PASS;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      res_q   <= RES_PASS;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      res_q   <= res_d;
    end
  end

  assign done_o   = done_q;
  assign status_o = res_q;

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: status changes only together with done
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(res_q));

  // R5: the second re-check read always ends the run with pass or fail
  a_r5_recheck_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHK_B) && fire |=> done_q && (res_q != RES_TIMEOUT));

  // R7: done is never raised while a run is still in progress
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));

  // R5: bit 5 during polling never leads directly to a result
  a_r5_err_rechecks: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FIRST) || (state_q == ST_NEXT)) && fire && err_i |=> !done_q && (state_q == ST_CHK_A));

endmodule

// File: rtl/flash_toggle_poll.sv
module flash_toggle_poll
  import ftp_pkg::*;
#(
  parameter int unsigned AW = 17,
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [CW-1:0]     limit_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q    <= rst_s1_q;
    end
  end

  logic          accept;
  logic          ref_load;
  logic          cnt_arm;
  logic          cnt_inc;
  logic          differs;
  logic          last;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (accept) addr_d = addr_i;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  ftp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_q),
    .start_i    (start_i),
    .ack_i      (rd_ack_i),
    .tog_i      (rd_data_i[TOGGLE_BIT]),
    .err_i      (rd_data_i[ERROR_BIT]),
    .differs_i  (differs),
    .last_i     (last),
    .accept_o   (accept),
    .req_o      (rd_req_o),
    .ref_load_o (ref_load),
    .cnt_arm_o  (cnt_arm),
    .cnt_inc_o  (cnt_inc),
    .done_o     (done_o),
    .status_o   (status_o)
  );

  ftp_ref_reg u_ref (
    .clk       (clk),
    .rst_n     (rst_q),
    .load_i    (ref_load),
    .bit_i     (rd_data_i[TOGGLE_BIT]),
    .differs_o (differs)
  );

  ftp_pair_cnt #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_q),
    .arm_i   (cnt_arm),
    .inc_i   (cnt_inc),
    .limit_i (limit_i),
    .last_o  (last)
  );

  assign rd_addr_o = addr_q;
  assign busy_o    = rd_req_o;

  // R2: an outstanding request is held until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_q)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

  // R6: start while busy leaves the polled address untouched
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_q)
    busy_o && start_i |=> $stable(addr_q));

endmodule

// File: tb/flash_toggle_poll_bench.sv
`timescale 1ns/1ps
module flash_toggle_poll_bench;

  localparam int AW = 17;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] addr_i;
  logic [CW-1:0] limit_i;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_ack_i;
  logic [7:0]    rd_data_i;
  logic          busy_o;
  logic          done_o;
  logic [1:0]    status_o;

  always #2.5 clk = ~clk;

  flash_toggle_poll #(.AW(AW), .CW(CW)) u_flash_toggle_poll (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .limit_i(limit_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
    .done_o(done_o), .status_o(status_o)
  );

  int total = 0;
  int bad   = 0;
  int rd_idx;
  int cur_t, cur_e;
  logic [AW-1:0] cur_addr;
  int addr_err;
  int done_cnt;
  int dummy;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit tog_of(int r, int t);
    return 1'((r < t ? r : t) & 1);
  endfunction

  // expected result from the requirements: st status, nr reads, path tag
  function automatic void exp_run(input int t, input int e, input int lim,
                                  output int st, output int nr, output int path);
    int  r = 0;
    int  le = (lim == 0) ? 1 : lim;
    int  cnt = 0;
    bit  rf = 0;
    bit  have = 0;
    bit  fin = 0;
    bit  b6, a, b;
    st = 0; nr = 0; path = 0;
    while (!fin) begin
      b6 = tog_of(r, t);
      if (r >= e) begin
        r++;
        a = tog_of(r, t); r++;
        b = tog_of(r, t); r++;
        st = (a == b) ? 0 : 1; path = 1; fin = 1;
      end else begin
        r++;
        if (have && (b6 == rf)) begin
          st = 0; path = 0; fin = 1;
        end else begin
          if (have) begin
            cnt++;
            if (cnt >= le) begin st = 2; path = 2; fin = 1; end
          end
          rf = b6; have = 1;
        end
      end
    end
    nr = r;
  endfunction

  // flash responder
  always @(negedge clk) begin
    if (rd_ack_i === 1'b1) rd_idx++;
    if (rd_req_o === 1'b1 && rst_n) begin
      rd_ack_i  <= ($urandom % 3) != 0;
      rd_data_i <= {1'($urandom), tog_of(rd_idx, cur_t), 1'(rd_idx >= cur_e), 5'($urandom)};
      if (rd_addr_o !== cur_addr) addr_err++;
    end else begin
      rd_ack_i  <= 1'b0;
      rd_data_i <= 8'($urandom);
    end
    if (done_o === 1'b1) done_cnt++;
  end

  task automatic run(input int t, input int e, input int lim,
                     input logic [AW-1:0] addr, input bit poke);
    int st, nr, path, cyc;
    logic [1:0] got;
    string tag;
    bit seen;
    exp_run(t, e, lim, st, nr, path);
    tag = (path == 1) ? "R5" : ((path == 2) ? "R4" : "R3");
    @(negedge clk);
    cur_t = t; cur_e = e; cur_addr = addr;
    rd_idx = 0; done_cnt = 0; addr_err = 0;
    start_i = 1'b1; addr_i = addr; limit_i = CW'(lim);
    @(negedge clk);
    start_i = 1'b0; addr_i = AW'($urandom);
    seen = 0;
    for (cyc = 0; cyc < 3000 && !seen; cyc++) begin
      @(negedge clk);
      if (start_i) start_i = 1'b0;
      if (done_o) seen = 1;
      else if (poke && cyc == 2 && busy_o) begin
        start_i = 1'b1; addr_i = addr ^ AW'(1); limit_i = '1;
      end
    end
    chk(seen, "R7", "run finished", int'(seen), 1);
    got = status_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R7", "done width one cycle", int'(done_o), 0);
    chk(busy_o == 1'b0, "R7", "idle after done", int'(busy_o), 0);
    chk(got == 2'(st), tag, "status", int'(got), st);
    chk(rd_idx == nr, tag, "read count", rd_idx, nr);
    chk(addr_err == 0, "R2", "read address mismatches", addr_err, 0);
    chk(done_cnt == 1, poke ? "R6" : "R7", "done pulses", done_cnt, 1);
    repeat (3) @(negedge clk);
    chk(status_o == got && !busy_o, "R7", "status held", int'(status_o), int'(got));
  endtask

  bit wd_hit = 0;
  initial begin
    #(200000 * 5);
    wd_hit = 1;
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    dummy = $urandom(32'h5eed_1234);
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; limit_i = '0;
    rd_ack_i = 1'b0; rd_data_i = '0;
    cur_t = 0; cur_e = 1000; cur_addr = '0;
    rd_idx = 0; addr_err = 0; done_cnt = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !rd_req_o, "R1", "outputs in reset",
        int'({busy_o, done_o, rd_req_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(status_o == 2'b00 && !rd_req_o, "R1", "status after reset", int'(status_o), 0);

    run(0,  1000, 4,  17'h00010, 0);  // R3 immediate stability
    run(5,  1000, 10, 17'h1abcd, 0);  // R3 stops after five toggles
    run(5,  1000, 5,  17'h00fff, 0);  // R4 bound hit exactly
    run(30, 1000, 0,  17'h00123, 0);  // R4 limit 0 acts as 1
    run(4,  3,    8,  17'h0aaaa, 0);  // R5 re-check passes
    run(10, 3,    8,  17'h15555, 0);  // R5 re-check fails
    run(1,  0,    8,  17'h00001, 0);  // R5 error on first read
    run(8,  1000, 20, 17'h0c0de, 1);  // R6 start while busy

    for (int i = 0; i < 40; i++) begin
      int t, e, lim;
      t   = int'($urandom % 20);
      e   = (($urandom % 3) == 0) ? int'($urandom % 25) : 1000;
      lim = int'($urandom % 22);
      run(t, e, lim, AW'($urandom), 1'($urandom % 4 == 0));
    end

    if (!wd_hit) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule